// File: doc/BRIEF.md
# Ordered Masked Rule Classifier

This block keeps a small table of classification rules and tests one parsed packet header key against all of them every clock. The key holds nine header fields, each with its own valid flag: VLAN ID, IP protocol number, ethertype, destination and source L4 port, destination and source IPv4 address, and destination and source MAC address. Every rule has a value, a per-bit mask and a per-field enable for each field. It also has an action code and a destination port. The result names the lowest-numbered enabled rule whose enabled fields all match, or reports that no rule matched. The key is assumed to have been extracted by an upstream parser from the leading 128 bytes of the frame.

Software builds a rule word by word in a staging area through a narrow write port. One commit command then copies the whole staged rule into a table slot, so a lookup never sees half a rule. A separate command switches a slot on or off without touching its contents. Both commands may be issued while keys stream in at one per clock. Results leave in key order, at a fixed latency.

Top module: `rule_classifier`

## Requirements
- R1: After reset every table slot is disabled, so a lookup returns resHit=0 until a slot is switched on.
- R2: A key sampled with keyValid=1 on clock edge N produces resValid=1 with its result after edge N+2. Keys may arrive on consecutive edges, and results come out in the same order, one per cycle. resValid is 0 when no key was sampled two edges earlier.
- R3: When several enabled rules match, resIndex, resAction and resDest all come from the lowest-numbered one.
- R4: A field whose enable bit is 0 is ignored, whatever the key holds in it. A rule with no field enabled matches every key.
- R5: Inside an enabled field, only bit positions whose mask bit is 1 are compared with the rule value.
- R6: An enabled field matches only if its keyFieldValid bit is 1. Field index i (valid bit i, enable bit i, and keyData bits from LSB up) is: 0 VLAN ID 12b [11:0], 1 IP protocol 8b [19:12], 2 ethertype 16b [35:20], 3 destination L4 port 16b [51:36], 4 source L4 port 16b [67:52], 5 destination IPv4 32b [99:68], 6 source IPv4 32b [131:100], 7 destination MAC 48b [179:132], 8 source MAC 48b [227:180].
- R7: A disabled slot never matches, whatever it contains.
- R8: Writes with cfgSel 0 to 7 fill 32-bit words of the staged value, LSB word first. Writes with 8 to 15 fill the staged mask the same way. cfgSel 16 loads the staged field enables [8:0], action [10:9] and destination [31:16]. None of these writes changes any lookup result. cfgSel 17 (commit) copies the whole staged rule into slot cfgWrData[15:0] and sets that slot's enable to cfgWrData[31]. A key sampled on the commit edge or later sees the complete new rule; a key sampled earlier sees the complete old one.
- R9: cfgSel 18 sets the enable of slot cfgWrData[15:0] to cfgWrData[31] and leaves that slot's value, mask, enables, action and destination as they were.
- R10: When no rule matches, resHit=0 and resIndex, resAction and resDest are all 0. Action codes are 0 drop, 1 redirect, 2 mirror.
- R11: A commit or enable command whose slot number is NUM_RULES or more changes no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 5 | Configuration register select |
| cfgWrData | input | 32 | Configuration write data |
| keyValid | input | 1 | Key present this cycle |
| keyData | input | 228 | Packed header fields, layout in R6 |
| keyFieldValid | input | 9 | Per-field valid flags |
| resValid | output | 1 | Result present |
| resHit | output | 1 | A rule matched |
| resIndex | output | clog2(NUM_RULES) | Winning slot number |
| resAction | output | 2 | Action code of winning rule |
| resDest | output | DEST_W | Destination port of winning rule |

## Verification
A corrupted slot enable or a staged word landing in the wrong slot shows up as a wrong resHit or resIndex on the very next key that touches that slot, two edges after the key is sampled. A priority error only appears when two or more slots match at once, so the bench sweeps all 256 enable patterns of an eight-slot table. A mask or field-offset error only shows when the key differs from the rule value in a single bit, so every bit of every field is flipped in turn. Commits are issued on the same edge as a key, and on the edge after one, so that a torn update would show as a result mixing old and new action and destination.

// File: rtl/rule_cls_pkg.sv
package rule_cls_pkg;

  localparam int FIELD_CNT = 9;
  localparam int KEY_W     = 228;
  localparam int CFG_W     = 32;
  localparam int SEL_W     = 5;
  localparam int SLOT_W    = 16;

  localparam logic [SEL_W-1:0] SEL_CTRL   = 5'd16;
  localparam logic [SEL_W-1:0] SEL_COMMIT = 5'd17;
  localparam logic [SEL_W-1:0] SEL_ENABLE = 5'd18;

  typedef enum logic [1:0] {
    ACT_DROP     = 2'd0,
    ACT_REDIRECT = 2'd1,
    ACT_MIRROR   = 2'd2,
    ACT_RSVD     = 2'd3
  } act_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic              ruleWr;
    logic              enWr;
    logic              enVal;
    logic [SLOT_W-1:0] slot;
  } cfg_strobe_t;

  function automatic int fieldWidth(input int f);
    case (f)
      0:       return 12;
      1:       return 8;
      2, 3, 4: return 16;
      5, 6:    return 32;
      default: return 48;
    endcase
  endfunction

  function automatic int fieldLsb(input int f);
    int acc;
    acc = 0;
    for (int i = 0; i < f; i++) acc += fieldWidth(i);
    return acc;
  endfunction

endpackage

// File: rtl/rule_cfg_ctrl.sv
module rule_cfg_ctrl
  import rule_cls_pkg::*;
#(
  parameter int DEST_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrEn,
  input  logic [SEL_W-1:0]     cfgSel,
  input  logic [CFG_W-1:0]     cfgWrData,
  output cfg_strobe_t          strobe,
  output logic [KEY_W-1:0]     stVal,
  output logic [KEY_W-1:0]     stMask,
  output logic [FIELD_CNT-1:0] stFieldEn,
  output logic [1:0]           stAction,
  output logic [DEST_W-1:0]    stDest
);

  localparam int WORD_SEL_W = $clog2((KEY_W + CFG_W - 1) / CFG_W);

  logic isMaskWr;
  logic isValWr;
  logic [WORD_SEL_W-1:0] wordSel;

  assign wordSel  = cfgSel[WORD_SEL_W-1:0];
  assign isValWr  = cfgWrEn && (cfgSel[SEL_W-1:WORD_SEL_W] == '0);
  assign isMaskWr = cfgWrEn && (cfgSel[SEL_W-1:WORD_SEL_W] == 2'd1);

  // Staging area, written bit by bit from the selected word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stVal     <= '0;
      stMask    <= '0;
      stFieldEn <= '0;
      stAction  <= '0;
      stDest    <= '0;
    end else begin
      for (int b = 0; b < KEY_W; b++) begin
        if (isValWr && (wordSel == WORD_SEL_W'(b / CFG_W)))
          stVal[b] <= cfgWrData[b % CFG_W];
        if (isMaskWr && (wordSel == WORD_SEL_W'(b / CFG_W)))
          stMask[b] <= cfgWrData[b % CFG_W];
      end
      if (cfgWrEn && cfgSel == SEL_CTRL) begin
        stFieldEn <= cfgWrData[FIELD_CNT-1:0];
        stAction  <= cfgWrData[10:9];
        stDest    <= cfgWrData[16 +: DEST_W];
      end
    end
  end

  always_comb begin
    strobe.ruleWr = cfgWrEn && (cfgSel == SEL_COMMIT);
    strobe.enWr   = cfgWrEn && (cfgSel == SEL_ENABLE);
    strobe.enVal  = cfgWrData[CFG_W-1];
    strobe.slot   = cfgWrData[SLOT_W-1:0];
  end

endmodule

// File: rtl/rule_match_dp.sv
module rule_match_dp
  import rule_cls_pkg::*;
#(
  parameter int NUM_RULES = 32,
  parameter int DEST_W    = 4,
  localparam int IDX_W    = $clog2(NUM_RULES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  cfg_strobe_t          strobe,
  input  logic [KEY_W-1:0]     stVal,
  input  logic [KEY_W-1:0]     stMask,
  input  logic [FIELD_CNT-1:0] stFieldEn,
  input  logic [1:0]           stAction,
  input  logic [DEST_W-1:0]    stDest,
  input  logic                 keyValid,
  input  logic [KEY_W-1:0]     keyData,
  input  logic [FIELD_CNT-1:0] keyFieldValid,
  output logic                 resValid,
  output logic                 resHit,
  output logic [IDX_W-1:0]     resIndex,
  output logic [1:0]           resAction,
  output logic [DEST_W-1:0]    resDest
);

  // Rule table
  logic [KEY_W-1:0]     ruleVal   [NUM_RULES];
  logic [KEY_W-1:0]     ruleMask  [NUM_RULES];
  logic [FIELD_CNT-1:0] ruleFldEn [NUM_RULES];
  logic [1:0]           ruleAct   [NUM_RULES];
  logic [DEST_W-1:0]    ruleDest  [NUM_RULES];
  logic [NUM_RULES-1:0] ruleOn;

  logic slotOk;
  logic [IDX_W-1:0] slotIdx;

  assign slotOk  = int'(strobe.slot) < NUM_RULES;
  assign slotIdx = strobe.slot[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (strobe.ruleWr && slotOk) begin
      ruleVal[slotIdx]   <= stVal;
      ruleMask[slotIdx]  <= stMask;
      ruleFldEn[slotIdx] <= stFieldEn;
      ruleAct[slotIdx]   <= stAction;
      ruleDest[slotIdx]  <= stDest;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ruleOn <= '0;
    else if ((strobe.ruleWr || strobe.enWr) && slotOk) ruleOn[slotIdx] <= strobe.enVal;
  end

  // Key acceptance stage
  logic                 s1Valid;
  logic [KEY_W-1:0]     s1Key;
  logic [FIELD_CNT-1:0] s1Fv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Key   <= '0;
      s1Fv    <= '0;
    end else begin
      s1Valid <= keyValid;
      s1Key   <= keyData;
      s1Fv    <= keyFieldValid;
    end
  end

  // Parallel compare of every rule
  logic [NUM_RULES-1:0] hit;

  for (genvar r = 0; r < NUM_RULES; r++) begin : g_rule
    logic [KEY_W-1:0]     diff;
    logic [FIELD_CNT-1:0] fieldOk;
    assign diff = (s1Key ^ ruleVal[r]) & ruleMask[r];
    for (genvar f = 0; f < FIELD_CNT; f++) begin : g_field
      localparam int LO = fieldLsb(f);
      localparam int FW = fieldWidth(f);
      assign fieldOk[f] = !ruleFldEn[r][f] || (s1Fv[f] && (diff[LO +: FW] == '0));
    end
    assign hit[r] = ruleOn[r] && (&fieldOk);
  end

  // Lowest index wins; table read in the same cycle as the compare
  logic              selHit;
  logic [IDX_W-1:0]  selIdx;
  logic [1:0]        selAct;
  logic [DEST_W-1:0] selDest;

  always_comb begin
    selHit  = 1'b0;
    selIdx  = '0;
    selAct  = '0;
    selDest = '0;
    for (int r = NUM_RULES - 1; r >= 0; r--) begin
      if (hit[r]) begin
        selHit  = 1'b1;
        selIdx  = IDX_W'(r);
        selAct  = ruleAct[r];
        selDest = ruleDest[r];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid  <= 1'b0;
      resHit    <= 1'b0;
      resIndex  <= '0;
      resAction <= '0;
      resDest   <= '0;
    end else begin
      resValid  <= s1Valid;
      resHit    <= selHit;
      resIndex  <= selIdx;
      resAction <= selAct;
      resDest   <= selDest;
    end
  end

endmodule

// File: rtl/rule_classifier.sv
module rule_classifier
  import rule_cls_pkg::*;
#(
  parameter int NUM_RULES = 32,
  parameter int DEST_W    = 4,
  localparam int IDX_W    = $clog2(NUM_RULES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [4:0]        cfgSel,
  input  logic [31:0]       cfgWrData,
  input  logic              keyValid,
  input  logic [227:0]      keyData,
  input  logic [8:0]        keyFieldValid,
  output logic              resValid,
  output logic              resHit,
  output logic [IDX_W-1:0]  resIndex,
  output logic [1:0]        resAction,
  output logic [DEST_W-1:0] resDest
);

  cfg_strobe_t          strobe;
  logic [KEY_W-1:0]     stVal;
  logic [KEY_W-1:0]     stMask;
  logic [FIELD_CNT-1:0] stFieldEn;
  logic [1:0]           stAction;
  logic [DEST_W-1:0]    stDest;

  rule_cfg_ctrl #(.DEST_W(DEST_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgSel    (cfgSel),
    .cfgWrData (cfgWrData),
    .strobe    (strobe),
    .stVal     (stVal),
    .stMask    (stMask),
    .stFieldEn (stFieldEn),
    .stAction  (stAction),
    .stDest    (stDest)
  );

  rule_match_dp #(.NUM_RULES(NUM_RULES), .DEST_W(DEST_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .stVal         (stVal),
    .stMask        (stMask),
    .stFieldEn     (stFieldEn),
    .stAction      (stAction),
    .stDest        (stDest),
    .keyValid      (keyValid),
    .keyData       (keyData),
    .keyFieldValid (keyFieldValid),
    .resValid      (resValid),
    .resHit        (resHit),
    .resIndex      (resIndex),
    .resAction     (resAction),
    .resDest       (resDest)
  );

endmodule

// File: rtl/rule_classifier_chk.sv
module rule_classifier_chk #(
  parameter int NUM_RULES = 32,
  parameter int DEST_W    = 4,
  localparam int IDX_W    = $clog2(NUM_RULES)
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrEn,
  input logic [4:0]        cfgSel,
  input logic [16:0]       cmdData,
  input logic              keyValid,
  input logic              resValid,
  input logic              resHit,
  input logic [IDX_W-1:0]  resIndex,
  input logic [1:0]        resAction,
  input logic [DEST_W-1:0] resDest
);

  // Set once any in-range command has switched a slot on
  logic everOn;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) everOn <= 1'b0;
    else if (cfgWrEn && (cfgSel == 5'd17 || cfgSel == 5'd18) && cmdData[16]
             && int'(cmdData[15:0]) < NUM_RULES)
      everOn <= 1'b1;
  end

  assert_key_to_result_R2: assert property (@(posedge clk) disable iff (!rstN)
    keyValid |=> ##1 resValid);

  assert_result_has_key_R2: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> $past(keyValid, 2));

  assert_miss_zeroed_R10: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resHit) |-> (resIndex == '0 && resAction == 2'd0 && resDest == '0));

  assert_no_hit_before_enable_R1: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resHit) |-> everOn);

endmodule

bind rule_classifier rule_classifier_chk #(.NUM_RULES(NUM_RULES), .DEST_W(DEST_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cfgWrEn   (cfgWrEn),
  .cfgSel    (cfgSel),
  .cmdData   ({cfgWrData[31], cfgWrData[15:0]}),
  .keyValid  (keyValid),
  .resValid  (resValid),
  .resHit    (resHit),
  .resIndex  (resIndex),
  .resAction (resAction),
  .resDest   (resDest)
);

// File: tb/rule_classifier_tb.sv
module rule_classifier_tb;

  localparam int NR = 8;
  localparam int DW = 4;
  localparam int IW = 3;
  localparam int KW = 228;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rstN;
  logic          cfgWrEn;
  logic [4:0]    cfgSel;
  logic [31:0]   cfgWrData;
  logic          keyValid;
  logic [KW-1:0] keyData;
  logic [8:0]    keyFieldValid;
  logic          resValid;
  logic          resHit;
  logic [IW-1:0] resIndex;
  logic [1:0]    resAction;
  logic [DW-1:0] resDest;

  rule_classifier #(.NUM_RULES(NR), .DEST_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgWrData(cfgWrData),
    .keyValid(keyValid), .keyData(keyData), .keyFieldValid(keyFieldValid),
    .resValid(resValid), .resHit(resHit), .resIndex(resIndex),
    .resAction(resAction), .resDest(resDest)
  );

  int testsRun = 0;
  int testsFailed = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Field layout from R6
  function automatic int fw(input int f);
    case (f)
      0: return 12;
      1: return 8;
      2, 3, 4: return 16;
      5, 6: return 32;
      default: return 48;
    endcase
  endfunction

  function automatic int fl(input int f);
    int a;
    a = 0;
    for (int i = 0; i < f; i++) a += fw(i);
    return a;
  endfunction

  function automatic logic [KW-1:0] setField(input logic [KW-1:0] k, input int f,
                                             input logic [47:0] v);
    for (int b = 0; b < fw(f); b++) k[fl(f) + b] = v[b];
    return k;
  endfunction

  function automatic logic [KW-1:0] randKey();
    logic [255:0] t;
    for (int w = 0; w < 8; w++) t[w*32 +: 32] = $urandom();
    return t[KW-1:0];
  endfunction

  task automatic cfgWrite(input logic [4:0] s, input logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = s; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic stageRule(input logic [KW-1:0] v, input logic [KW-1:0] m,
                           input logic [8:0] en, input logic [1:0] act, input logic [15:0] dst);
    logic [255:0] pv;
    logic [255:0] pm;
    pv = {28'b0, v};
    pm = {28'b0, m};
    for (int w = 0; w < 8; w++) cfgWrite(5'(w), pv[w*32 +: 32]);
    for (int w = 0; w < 8; w++) cfgWrite(5'(8 + w), pm[w*32 +: 32]);
    cfgWrite(5'd16, {dst, 5'b0, act, en});
  endtask

  task automatic commitRule(input logic [15:0] slot, input logic en);
    cfgWrite(5'd17, {en, 15'b0, slot});
  endtask

  task automatic setEnable(input logic [15:0] slot, input logic en);
    cfgWrite(5'd18, {en, 15'b0, slot});
  endtask

  task automatic lookup(input logic [KW-1:0] k, input logic [8:0] fv);
    @(negedge clk);
    keyValid = 1'b1; keyData = k; keyFieldValid = fv;
    @(negedge clk);
    keyValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic expectRes(input string req, input bit h, input int idx,
                           input int act, input int dst);
    check(resValid == 1'b1, req, "resValid", longint'(resValid), 1);
    check(resHit == h, req, "resHit", longint'(resHit), longint'(h));
    check(int'(resIndex) == idx, req, "resIndex", longint'(resIndex), longint'(idx));
    check(int'(resAction) == act, req, "resAction", longint'(resAction), longint'(act));
    check(int'(resDest) == dst, req, "resDest", longint'(resDest), longint'(dst));
  endtask

  task automatic disableAll();
    for (int r = 0; r < NR; r++) setEnable(16'(r), 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    testsFailed++;
    $display("FAIL R2 watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [KW-1:0] allOnes;
    logic [KW-1:0] k;
    logic [47:0] vpat;
    logic [47:0] mpat;
    allOnes = '1;
    vpat = 48'hA5C3_1E0F_9B72;

    rstN = 1'b0; cfgWrEn = 1'b0; cfgSel = '0; cfgWrData = '0;
    keyValid = 1'b0; keyData = '0; keyFieldValid = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(resValid == 1'b0, "R1", "resValid in reset", longint'(resValid), 0);
    rstN = 1'b1;

    // R1: empty table misses
    lookup(randKey(), 9'h1FF);
    expectRes("R1", 1'b0, 0, 0, 0);

    // R3 R7 R9 R10 R4: catch-all rules, sweep every enable pattern
    for (int r = 0; r < NR; r++) begin
      stageRule(randKey(), randKey(), 9'h000, 2'(r % 3), 16'((r + 5) % 16));
      commitRule(16'(r), 1'b0);
    end
    for (int p = 0; p < 256; p++) begin
      int low;
      for (int r = 0; r < NR; r++) setEnable(16'(r), p[r]);
      lookup(randKey(), 9'(p));
      low = -1;
      for (int r = NR - 1; r >= 0; r--) if (p[r]) low = r;
      if (low < 0) expectRes("R10_R7", 1'b0, 0, 0, 0);
      else expectRes("R3_R9_R4", 1'b1, low, low % 3, (low + 5) % 16);
    end

    // R5 R6 R4: single-field rule, flip each bit of each field
    disableAll();
    for (int f = 0; f < 9; f++) begin
      mpat = '0;
      for (int b = 0; b < 48; b++) mpat[b] = (b % 3) != 0;
      stageRule(setField('0, f, vpat), setField('0, f, mpat), 9'(1 << f), 2'd1, 16'(f));
      commitRule(16'd0, 1'b1);
      for (int b = 0; b < fw(f); b++) begin
        lookup(setField(randKey(), f, vpat ^ (48'd1 << b)), 9'h1FF);
        if (b % 3 == 0) expectRes("R5", 1'b1, 0, 1, f);
        else expectRes("R5", 1'b0, 0, 0, 0);
      end
      k = setField(randKey(), f, vpat);
      lookup(k, 9'h1FF & ~(9'd1 << f));
      expectRes("R6", 1'b0, 0, 0, 0);
      lookup(k, 9'(1 << f));
      expectRes("R6_R4", 1'b1, 0, 1, f);
    end

    // R2: back-to-back stream, VLAN exact-match rules
    for (int r = 0; r < NR; r++) begin
      stageRule(setField('0, 0, 48'(100 + r)), allOnes, 9'h001, 2'd2, 16'(r));
      commitRule(16'(r), 1'b1);
    end
    for (int j = 0; j < 11; j++) begin
      @(negedge clk);
      if (j == 1 || j == 10)
        check(resValid == 1'b0, "R2", "resValid idle", longint'(resValid), 0);
      if (j >= 2 && j < 10)
        expectRes("R2", 1'b1, ((j - 2) * 5) % 8, 2, ((j - 2) * 5) % 8);
      if (j < 8) begin
        keyValid = 1'b1;
        keyData = setField(randKey(), 0, 48'(100 + (j * 5) % 8));
        keyFieldValid = 9'h1FF;
      end else keyValid = 1'b0;
    end

    // R8: staging is invisible, commit is atomic
    disableAll();
    stageRule(randKey(), randKey(), 9'h000, 2'd1, 16'd3);
    commitRule(16'd2, 1'b1);
    stageRule(setField('0, 0, 48'h55), allOnes, 9'h001, 2'd0, 16'd7);
    lookup(setField(randKey(), 0, 48'h55), 9'h1FF);
    expectRes("R8", 1'b1, 2, 1, 3);
    @(negedge clk);
    keyValid = 1'b1; keyData = setField(randKey(), 0, 48'h55); keyFieldValid = 9'h1FF;
    @(negedge clk);
    keyData = setField(randKey(), 0, 48'h55);
    cfgWrEn = 1'b1; cfgSel = 5'd17; cfgWrData = {1'b1, 15'b0, 16'd2};
    @(negedge clk);
    cfgWrEn = 1'b0;
    keyData = setField(randKey(), 0, 48'h66);
    expectRes("R8", 1'b1, 2, 1, 3);
    @(negedge clk);
    keyValid = 1'b0;
    expectRes("R8", 1'b1, 2, 0, 7);
    @(negedge clk);
    expectRes("R8", 1'b0, 0, 0, 0);

    // R11: out-of-range slots do not alias
    disableAll();
    stageRule(randKey(), randKey(), 9'h000, 2'd2, 16'd9);
    commitRule(16'd8, 1'b1);
    setEnable(16'd9, 1'b1);
    lookup(setField(randKey(), 0, 48'd101), 9'h1FF);
    expectRes("R11", 1'b0, 0, 0, 0);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule